// File: doc/BRIEF.md
# Register Ready-Bit Scoreboard

This block tracks, for every floating-point register, whether its value is available or is still waiting on an instruction in flight. The issue stage presents one instruction per cycle: a destination index, two source indices and two flags that say whether each source value could be forwarded from a result path instead of read from the file. The block answers with a stall in the same cycle. Checking one bit per register costs far less than comparing against every stage of every pipelined unit.

An issued instruction receives a short writer tag. The register records the tag and its bit drops to not-ready. A completion returns the destination and the tag. The bit comes back only if that tag still belongs to the latest writer of the register.

When an instruction overwrites a register that still has a write pending, and does not read that register itself, the block flags the older write as nulled and gives its tag. The execution side can then cancel that write. A late completion from the older write is ignored because its tag no longer matches.

Top module: `ready_scoreboard`

## Requirements
- R1: An issue that is not stalled clears the ready bit of its destination from the next cycle on. It is given the tag shown on `iss_tag`. Tags start at 0 and count up by one per accepted issue, wrapping modulo 2^TAG_W.
- R2: A completion whose tag equals the latest writer tag of a not-ready register sets that register's ready bit from the next cycle.
- R3: `iss_stall` is 1 in the same cycle when `iss_valid` is 1 and either source register is not ready while its forward flag is 0. It is 0 whenever `iss_valid` is 0.
- R4: A source whose forward flag is 1 never causes a stall, whatever its ready bit.
- R5: A stalled issue changes no ready bit and uses up no tag.
- R6: `null_valid` is 1 in the cycle of an accepted issue whose destination is not ready and equals neither of its sources. In that cycle `null_tag` carries the tag of the write being overtaken. `null_valid` is 0 at all other times.
- R7: A completion whose tag is not the register's latest writer tag leaves the ready bit at 0.
- R8: When an accepted issue and a matching completion name the same register in one cycle, the issue wins and the bit stays 0.
- R9: After reset every ready bit is 1 and the next tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_dst | input | 5 | Destination register index |
| iss_src_a | input | 5 | First source register index |
| iss_src_b | input | 5 | Second source register index |
| byp_a_ok | input | 1 | First source can be forwarded |
| byp_b_ok | input | 1 | Second source can be forwarded |
| cmp_valid | input | 1 | A result is being written back |
| cmp_dst | input | 5 | Register written back |
| cmp_tag | input | 4 | Writer tag of the completing instruction |
| iss_stall | output | 1 | Hold the presented instruction |
| iss_tag | output | 4 | Tag given to the instruction if accepted |
| null_valid | output | 1 | An older pending write is overtaken |
| null_tag | output | 4 | Tag of the overtaken write |
| ready_vec | output | 32 | Ready bit of each register |

## Verification
The hardest case to reach is a write that has been overtaken and then tries to complete late. To get there, the stimulus must first leave a write pending. It then issues a second writer to the same register that reads neither its own destination. Only after that does it return the first tag, and the bit must stay at 0. The bench builds this in three consecutive driver steps. It repeats the idea with the younger completion and the younger issue arriving in the same cycle, and with a younger writer that forwards its own destination, which must not null anything. A reference model of ready bits and tags, written from the requirements, predicts every stall, null and ready vector.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // one source blocks issue when its value is neither in the file nor forwardable
  function automatic logic operand_blocked(input logic rdy, input logic byp);
    return (!rdy) && (!byp);
  endfunction

  // an overtaken write is cancelled unless the new writer consumes the old value
  function automatic logic overtakes(input logic fire, input logic dst_rdy,
                                     input logic dst_read);
    return fire && !dst_rdy && !dst_read;
  endfunction

endpackage

// File: rtl/sb_tag_alloc.sv
module sb_tag_alloc #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       tag <= '0;
    else if (advance) tag <= tag + 1'b1;
  end
endmodule

// File: rtl/sb_reg_entry.sv
module sb_reg_entry #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [TAG_W-1:0] claim_tag,
  input  logic             release_i,
  output logic             ready,
  output logic [TAG_W-1:0] owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b1;
      owner <= '0;
    end else if (claim) begin
      ready <= 1'b0;
      owner <= claim_tag;
    end else if (release_i) begin
      ready <= 1'b1;
    end
  end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard (
  input  logic iss_valid,
  input  logic rdy_a,
  input  logic rdy_b,
  input  logic byp_a,
  input  logic byp_b,
  input  logic rdy_dst,
  input  logic dst_read,
  output logic stall,
  output logic fire,
  output logic nullify
);
  import sb_pkg::*;
  always_comb begin
    stall   = iss_valid && (operand_blocked(rdy_a, byp_a) || operand_blocked(rdy_b, byp_b));
    fire    = iss_valid && !stall;
    nullify = overtakes(fire, rdy_dst, dst_read);
  end
endmodule

// File: rtl/ready_scoreboard.sv
module ready_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_valid,
  input  logic [IDX_W-1:0]    iss_dst,
  input  logic [IDX_W-1:0]    iss_src_a,
  input  logic [IDX_W-1:0]    iss_src_b,
  input  logic                byp_a_ok,
  input  logic                byp_b_ok,
  input  logic                cmp_valid,
  input  logic [IDX_W-1:0]    cmp_dst,
  input  logic [TAG_W-1:0]    cmp_tag,
  output logic                iss_stall,
  output logic [TAG_W-1:0]    iss_tag,
  output logic                null_valid,
  output logic [TAG_W-1:0]    null_tag,
  output logic [NUM_REGS-1:0] ready_vec
);
  logic [TAG_W-1:0] owner [NUM_REGS];
  logic             issue_fire;
  logic             cmp_accept;
  logic             dst_read;

  assign dst_read = (iss_dst == iss_src_a) || (iss_dst == iss_src_b);

  sb_hazard u_haz (
    .iss_valid (iss_valid),
    .rdy_a     (ready_vec[iss_src_a]),
    .rdy_b     (ready_vec[iss_src_b]),
    .byp_a     (byp_a_ok),
    .byp_b     (byp_b_ok),
    .rdy_dst   (ready_vec[iss_dst]),
    .dst_read  (dst_read),
    .stall     (iss_stall),
    .fire      (issue_fire),
    .nullify   (null_valid)
  );

  sb_tag_alloc #(.TAG_W(TAG_W)) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (issue_fire),
    .tag     (iss_tag)
  );

  assign null_tag   = owner[iss_dst];
  assign cmp_accept = cmp_valid && !ready_vec[cmp_dst] && (cmp_tag == owner[cmp_dst])
                      && !(issue_fire && (iss_dst == cmp_dst));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    sb_reg_entry #(.TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim     (issue_fire && (iss_dst == IDX_W'(g))),
      .claim_tag (iss_tag),
      .release_i (cmp_accept && (cmp_dst == IDX_W'(g))),
      .ready     (ready_vec[g]),
      .owner     (owner[g])
    );
  end
endmodule

// File: rtl/ready_scoreboard_chk.sv
module ready_scoreboard_chk #(
  parameter int NUM_REGS = 32,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_valid,
  input logic [IDX_W-1:0]    iss_dst,
  input logic [IDX_W-1:0]    iss_src_a,
  input logic [IDX_W-1:0]    iss_src_b,
  input logic                byp_a_ok,
  input logic                byp_b_ok,
  input logic                cmp_valid,
  input logic [IDX_W-1:0]    cmp_dst,
  input logic                iss_stall,
  input logic                null_valid,
  input logic [NUM_REGS-1:0] ready_vec,
  input logic                issue_fire,
  input logic                cmp_accept
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !ready_vec[$past(iss_dst)]);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_accept |=> ready_vec[$past(cmp_dst)]);
  assert_stall_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !ready_vec[iss_src_a] && !byp_a_ok) |-> iss_stall);
  assert_stall_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !ready_vec[iss_src_b] && !byp_b_ok) |-> iss_stall);
  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !iss_stall);
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && byp_a_ok && byp_b_ok) |-> !iss_stall);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_stall && !cmp_valid) |=> $stable(ready_vec));
  assert_null_R6: assert property (@(posedge clk) disable iff (!rst_n)
    null_valid |-> (issue_fire && !ready_vec[iss_dst]));
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_accept && !ready_vec[cmp_dst]) |=> !ready_vec[$past(cmp_dst)]);
  assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && cmp_valid && (cmp_dst == iss_dst)) |=> !ready_vec[$past(iss_dst)]);
endmodule

bind ready_scoreboard ready_scoreboard_chk #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_dst    (iss_dst),
  .iss_src_a  (iss_src_a),
  .iss_src_b  (iss_src_b),
  .byp_a_ok   (byp_a_ok),
  .byp_b_ok   (byp_b_ok),
  .cmp_valid  (cmp_valid),
  .cmp_dst    (cmp_dst),
  .iss_stall  (iss_stall),
  .null_valid (null_valid),
  .ready_vec  (ready_vec),
  .issue_fire (issue_fire),
  .cmp_accept (cmp_accept)
);

// File: tb/ready_scoreboard_tb.sv
module ready_scoreboard_tb;
  localparam int NR = 32;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0, byp_a_ok = 1'b0, byp_b_ok = 1'b0, cmp_valid = 1'b0;
  logic [4:0]    iss_dst = '0, iss_src_a = '0, iss_src_b = '0, cmp_dst = '0;
  logic [TW-1:0] cmp_tag = '0;
  logic          iss_stall, null_valid;
  logic [TW-1:0] iss_tag, null_tag;
  logic [NR-1:0] ready_vec;

  always #4 clk = ~clk;

  ready_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .byp_a_ok(byp_a_ok),
    .byp_b_ok(byp_b_ok), .cmp_valid(cmp_valid), .cmp_dst(cmp_dst),
    .cmp_tag(cmp_tag), .iss_stall(iss_stall), .iss_tag(iss_tag),
    .null_valid(null_valid), .null_tag(null_tag), .ready_vec(ready_vec)
  );

  typedef struct {
    string         req;
    logic          stall;
    logic          fire;
    logic [TW-1:0] tag;
    logic          nullv;
    logic [TW-1:0] nullt;
    logic [NR-1:0] rdy;
  } exp_t;

  exp_t          q[$];
  int            checks = 0, fails = 0;
  bit            done = 1'b0;
  logic [NR-1:0] m_rdy;
  logic [TW-1:0] m_own [NR];
  logic [TW-1:0] m_tag;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what the model predicts
  task automatic step(input string req, input bit iv, input int d, input int a,
                      input int b, input bit ba, input bit bb, input bit cv,
                      input int cd, input int ct);
    exp_t e;
    logic st, fi, dread;
    @(negedge clk);
    iss_valid = iv; iss_dst = 5'(d); iss_src_a = 5'(a); iss_src_b = 5'(b);
    byp_a_ok = ba; byp_b_ok = bb; cmp_valid = cv; cmp_dst = 5'(cd); cmp_tag = TW'(ct);
    st    = iv && ((!m_rdy[a] && !ba) || (!m_rdy[b] && !bb));
    fi    = iv && !st;
    dread = (d == a) || (d == b);
    e.req = req; e.stall = st; e.fire = fi; e.tag = m_tag;
    e.nullv = fi && !m_rdy[d] && !dread;
    e.nullt = m_own[d];
    if (cv && !m_rdy[cd] && (TW'(ct) == m_own[cd]) && !(fi && d == cd)) m_rdy[cd] = 1'b1;
    if (fi) begin
      m_rdy[d] = 1'b0;
      m_own[d] = m_tag;
      m_tag    = m_tag + 1'b1;
    end
    e.rdy = m_rdy;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compares same-cycle outputs, then the state after the edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.req, "stall", 32'(iss_stall), 32'(e.stall));
        chk(e.req, "null_valid", 32'(null_valid), 32'(e.nullv));
        if (e.nullv) chk(e.req, "null_tag", 32'(null_tag), 32'(e.nullt));
        if (e.fire)  chk(e.req, "iss_tag", 32'(iss_tag), 32'(e.tag));
        @(posedge clk);
        #2;
        chk(e.req, "ready_vec", ready_vec, e.rdy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] old;
    m_rdy = '1;
    m_tag = '0;
    for (int i = 0; i < NR; i++) m_own[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "ready after reset", ready_vec, '1);
    chk("R9", "first tag", 32'(iss_tag), 0);
    idle("R9 idle");

    step("R1 issue d3", 1, 3, 1, 2, 0, 0, 0, 0, 0);
    step("R3 src_a stall", 1, 5, 3, 1, 0, 0, 0, 0, 0);
    step("R3 src_b stall", 1, 6, 1, 3, 0, 0, 0, 0, 0);
    step("R3 no valid", 0, 5, 3, 3, 0, 0, 0, 0, 0);
    step("R5 stall no tag use", 1, 13, 3, 3, 0, 0, 0, 0, 0);
    step("R4 bypass a", 1, 5, 3, 2, 1, 0, 0, 0, 0);
    step("R4 bypass both", 1, 6, 3, 5, 1, 1, 0, 0, 0);
    step("R2 complete d3", 0, 0, 0, 0, 0, 0, 1, 3, m_own[3]);
    step("R2 already ready", 0, 0, 0, 0, 0, 0, 1, 3, m_own[3]);
    step("R1 issue after ready", 1, 8, 3, 4, 0, 0, 0, 0, 0);

    step("R1 first writer d7", 1, 7, 1, 2, 0, 0, 0, 0, 0);
    old = m_own[7];
    step("R6 overtake d7", 1, 7, 1, 2, 0, 0, 0, 0, 0);
    step("R7 late old tag d7", 0, 0, 0, 0, 0, 0, 1, 7, old);
    idle("R7 hold");
    step("R2 young tag d7", 0, 0, 0, 0, 0, 0, 1, 7, m_own[7]);

    step("R1 writer d9", 1, 9, 1, 2, 0, 0, 0, 0, 0);
    step("R6 self read no null", 1, 9, 9, 1, 1, 0, 0, 0, 0);

    step("R1 writer d11", 1, 11, 1, 2, 0, 0, 0, 0, 0);
    step("R8 issue beats completion", 1, 11, 1, 2, 0, 0, 1, 11, m_own[11]);
    step("R8 stale tag after", 0, 0, 0, 0, 0, 0, 1, 11, (m_own[11] + 1) % 16);
    step("R2 finish d11", 0, 0, 0, 0, 0, 0, 1, 11, m_own[11]);

    for (int i = 0; i < 18; i++) step("R1 tag wrap", 1, 20 + (i % 4), 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2 drain", 0, 0, 0, 0, 0, 0, 1, 20 + i, m_own[20 + i]);
    idle("R9 end");
    idle("R9 end");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule